// File: doc/BRIEF.md
# Guarded-Update Triangle PWM Generator

This block produces one center-aligned gate signal from an up/down triangle carrier. A signed duty command enters on a single-cycle strobe, at any point in the carrier. The block maps the command onto the carrier's count range. It then decides whether the new compare value can be applied in the very next cycle, or must wait for the next carrier turning point (the valley or the peak).

The decision depends on which slope the carrier is on. A command is applied at once only if the gate has not yet made its transition for the current slope. Otherwise the block keeps the command in a shadow register and loads it at the coming turning point. If several commands are deferred within one slope, the newest one wins.

This rule keeps the switching frequency fixed. It also guarantees that each slope carries at most one gate edge, while a late command can still shorten the present pulse. A sample strobe marks the valley and the peak as points where the controller should measure. An optional third strobe marks the middle of each slope. A controller that samples on these strobes and answers after its own compute delay gets the shortest legal reaction time.

Top module: `tpwm_top`

## Requirements
- R1: The carrier counts 0,1,…,PEAK-1 with the rising flag high, then PEAK,PEAK-1,…,1 with it low, and repeats, for a period of 2·PEAK clocks. After reset it starts at 0 on the rising slope.
- R2: A duty command is a DUTY_W-bit two's-complement number d. Its compare value is floor((d + 2^(DUTY_W-1))·PEAK / 2^DUTY_W), so the most negative code gives 0 and the most positive code gives PEAK-1 or less.
- R3: On every cycle, the gate output is high exactly when the carrier output is below the compare output.
- R4: On the rising slope, a command whose cycle shows carrier < active compare is applied at once. The compare output shows the new value on the next cycle, together with a one-cycle early pulse.
- R5: On the rising slope, a command whose cycle shows carrier ≥ active compare raises a one-cycle defer pulse. The compare output keeps its value until it shows the command on the cycle where the carrier reads PEAK.
- R6: On the falling slope, a command is applied at once when carrier ≥ active compare. Otherwise it is deferred until the cycle where the carrier reads 0. Early and defer pulses behave as in R4 and R5.
- R7: When several commands are deferred within one slope, only the newest one is loaded at the turning point.
- R8: The gate rises at most once between consecutive peaks and falls at most once between consecutive valleys. It is always low while the carrier reads PEAK.
- R9: During reset, the carrier, compare, gate, early and defer outputs are all 0, and the rising flag is 1.
- R10: The sample strobe is high on cycles where the carrier reads 0 or PEAK. When MID_UPDATE is 1, it is also high where the carrier reads PEAK/2, on both slopes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cmd_valid_i | input | 1 | Duty command strobe |
| cmd_duty_i | input | DUTY_W | Signed duty command |
| gate_o | output | 1 | PWM gate output |
| cmp_o | output | CNT_W | Active compare value |
| carrier_o | output | CNT_W | Triangle carrier count |
| rising_o | output | 1 | High on the rising slope |
| sample_o | output | 1 | Sampling point strobe |
| early_o | output | 1 | Last command applied at once |
| defer_o | output | 1 | Last command deferred |

## Verification
The rule that decides between applying at once and deferring is tried with commands placed on both slopes, both before and after the gate crossing. This separates a block that compares against the wrong slope's crossing, or one that always waits, from a correct one. Repeated deferred commands within one slope show whether the shadow keeps the newest value or the first. The extreme codes show whether the mapping saturates correctly. A long run places commands at random and at a small delay after each sample strobe, including the cycles just before a turning point. Here a behavioural model and an edge counter expose any extra gate edge or misplaced reload.

// File: rtl/tpwm_pkg.sv
package tpwm_pkg;

  typedef enum logic {
    SLOPE_DN = 1'b0,
    SLOPE_UP = 1'b1
  } slope_e;

  // Linear map of a signed duty onto 0..peak-1 (floor).
  function automatic int duty_to_cmp(int duty, int duty_w, int peak);
    int off;
    off = duty + (1 << (duty_w - 1));
    return (off * peak) >>> duty_w;
  endfunction

  // True while the gate has not yet crossed for this slope.
  function automatic logic crossing_pending(logic rising, int cnt, int cmp);
    if (rising) return (cnt < cmp);
    return (cnt >= cmp);
  endfunction

endpackage

// File: rtl/tpwm_carrier.sv
module tpwm_carrier
  import tpwm_pkg::*;
#(
  parameter int PEAK       = 40,
  parameter int CNT_W      = 6,
  parameter bit MID_UPDATE = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             up_o,
  output logic             half_end_o,
  output logic             sample_o
);

  localparam logic [CNT_W-1:0] TOP  = CNT_W'(PEAK);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PEAK - 1);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(PEAK / 2);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  slope_e           dir_q, dir_nxt;
  logic             mid_hit;

  always_comb begin
    if (dir_q == SLOPE_UP) begin
      half_end_o = (cnt_q == LAST);
      cnt_nxt_o  = cnt_q + ONE;
    end else begin
      half_end_o = (cnt_q == ONE);
      cnt_nxt_o  = cnt_q - ONE;
    end
    if (half_end_o) dir_nxt = (dir_q == SLOPE_UP) ? SLOPE_DN : SLOPE_UP;
    else            dir_nxt = dir_q;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= SLOPE_UP;
    end else begin
      cnt_q <= cnt_nxt_o;
      dir_q <= dir_nxt;
    end
  end

  generate
    if (MID_UPDATE) begin : g_mid
      assign mid_hit = (cnt_q == MID);
    end else begin : g_nomid
      assign mid_hit = 1'b0;
    end
  endgenerate

  assign cnt_o    = cnt_q;
  assign up_o     = (dir_q == SLOPE_UP);
  assign sample_o = (cnt_q == '0) || (cnt_q == TOP) || mid_hit;

endmodule

// File: rtl/tpwm_arbiter.sv
module tpwm_arbiter
  import tpwm_pkg::*;
#(
  parameter int PEAK   = 40,
  parameter int CNT_W  = 6,
  parameter int DUTY_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [DUTY_W-1:0] cmd_duty_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              up_i,
  input  logic              half_end_i,
  output logic [CNT_W-1:0]  cmp_o,
  output logic [CNT_W-1:0]  cmp_nxt_o,
  output logic              early_o,
  output logic              defer_o,
  output logic              take_now_o,
  output logic              reload_o
);

  logic [CNT_W-1:0] cmp_q, shadow_q, shadow_nxt, new_cmp;
  logic             pend_q, pend_nxt;
  logic             early_q, defer_q;

  always_comb begin
    new_cmp    = CNT_W'(duty_to_cmp(int'($signed(cmd_duty_i)), DUTY_W, PEAK));
    take_now_o = cmd_valid_i && crossing_pending(up_i, int'(cnt_i), int'(cmp_q));
    cmp_nxt_o  = cmp_q;
    shadow_nxt = shadow_q;
    pend_nxt   = pend_q;
    if (take_now_o) begin
      cmp_nxt_o = new_cmp;
    end else if (cmd_valid_i) begin
      shadow_nxt = new_cmp;
      pend_nxt   = 1'b1;
    end
    reload_o = half_end_i && pend_nxt;
    if (reload_o) begin
      cmp_nxt_o = shadow_nxt;
      pend_nxt  = 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cmp_q    <= '0;
      shadow_q <= '0;
      pend_q   <= 1'b0;
      early_q  <= 1'b0;
      defer_q  <= 1'b0;
    end else begin
      cmp_q    <= cmp_nxt_o;
      shadow_q <= shadow_nxt;
      pend_q   <= pend_nxt;
      early_q  <= take_now_o;
      defer_q  <= cmd_valid_i && !take_now_o;
    end
  end

  assign cmp_o   = cmp_q;
  assign early_o = early_q;
  assign defer_o = defer_q;

endmodule

// File: rtl/tpwm_gate.sv
module tpwm_gate #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic [CNT_W-1:0] cmp_nxt_i,
  output logic             gate_o
);

  logic gate_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= (cnt_nxt_i < cmp_nxt_i);
  end

  assign gate_o = gate_q;

endmodule

// File: rtl/tpwm_top.sv
module tpwm_top
  import tpwm_pkg::*;
#(
  parameter int PEAK       = 40,
  parameter int DUTY_W     = 10,
  parameter bit MID_UPDATE = 1'b1,
  parameter int CNT_W      = $clog2(PEAK + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [DUTY_W-1:0] cmd_duty_i,
  output logic              gate_o,
  output logic [CNT_W-1:0]  cmp_o,
  output logic [CNT_W-1:0]  carrier_o,
  output logic              rising_o,
  output logic              sample_o,
  output logic              early_o,
  output logic              defer_o
);

  logic [CNT_W-1:0] cnt_w, cnt_nxt_w, cmp_nxt_w;
  logic             up_w, half_end_w;
  logic             take_now_w, reload_w;

  tpwm_carrier #(
    .PEAK(PEAK), .CNT_W(CNT_W), .MID_UPDATE(MID_UPDATE)
  ) u_carrier (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_o      (cnt_w),
    .cnt_nxt_o  (cnt_nxt_w),
    .up_o       (up_w),
    .half_end_o (half_end_w),
    .sample_o   (sample_o)
  );

  tpwm_arbiter #(
    .PEAK(PEAK), .CNT_W(CNT_W), .DUTY_W(DUTY_W)
  ) u_arbiter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_duty_i  (cmd_duty_i),
    .cnt_i       (cnt_w),
    .up_i        (up_w),
    .half_end_i  (half_end_w),
    .cmp_o       (cmp_o),
    .cmp_nxt_o   (cmp_nxt_w),
    .early_o     (early_o),
    .defer_o     (defer_o),
    .take_now_o  (take_now_w),
    .reload_o    (reload_w)
  );

  tpwm_gate #(.CNT_W(CNT_W)) u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_nxt_i (cnt_nxt_w),
    .cmp_nxt_i (cmp_nxt_w),
    .gate_o    (gate_o)
  );

  assign carrier_o = cnt_w;
  assign rising_o  = up_w;

endmodule

// File: rtl/tpwm_chk.sv
module tpwm_chk #(
  parameter int PEAK  = 40,
  parameter int CNT_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_valid_i,
  input logic             gate_o,
  input logic [CNT_W-1:0] cmp_o,
  input logic [CNT_W-1:0] carrier_o,
  input logic             rising_o,
  input logic             early_o,
  input logic             defer_o,
  input logic             take_now_w,
  input logic             reload_w
);

  logic gate_d, rose, fell, at_peak, at_valley;
  logic rise_seen, fall_seen;

  assign rose      = gate_o && !gate_d;
  assign fell      = !gate_o && gate_d;
  assign at_peak   = (carrier_o == CNT_W'(PEAK));
  assign at_valley = (carrier_o == '0) && rising_o;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      gate_d    <= 1'b0;
      rise_seen <= 1'b0;
      fall_seen <= 1'b0;
    end else begin
      gate_d <= gate_o;
      if (at_peak)   rise_seen <= rose;
      else if (rose) rise_seen <= 1'b1;
      if (at_valley) fall_seen <= fell;
      else if (fell) fall_seen <= 1'b1;
    end
  end

  p_carrier_up_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rising_o && carrier_o < CNT_W'(PEAK - 1)) |=> (carrier_o == $past(carrier_o) + 1'b1));

  p_carrier_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carrier_o <= CNT_W'(PEAK));

  p_gate_cmp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_o == (carrier_o < cmp_o));

  p_cmd_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> (early_o != defer_o));

  p_flags_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(early_o && defer_o));

  p_cmp_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!take_now_w && !reload_w) |=> $stable(cmp_o));

  p_peak_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_peak |-> !gate_o);

  p_one_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rose && !at_peak) |-> !rise_seen);

  p_one_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fell && !at_valley) |-> !fall_seen);

  p_rise_slope_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rose |-> (!rising_o || carrier_o == '0));

endmodule

bind tpwm_top tpwm_chk #(.PEAK(PEAK), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .gate_o      (gate_o),
  .cmp_o       (cmp_o),
  .carrier_o   (carrier_o),
  .rising_o    (rising_o),
  .early_o     (early_o),
  .defer_o     (defer_o),
  .take_now_w  (take_now_w),
  .reload_w    (reload_w)
);

// File: tb/tpwm_top_test.sv
module tpwm_top_test;

  localparam int PEAK  = 40;
  localparam int DW    = 10;
  localparam int CW    = $clog2(PEAK + 1);
  localparam int WDOG  = 150000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [DW-1:0] cmd_duty = '0;
  logic          gate, rising, sample, early, defer;
  logic [CW-1:0] cmp, carrier;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  tpwm_top #(.PEAK(PEAK), .DUTY_W(DW), .MID_UPDATE(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_duty_i(cmd_duty),
    .gate_o(gate), .cmp_o(cmp), .carrier_o(carrier), .rising_o(rising),
    .sample_o(sample), .early_o(early), .defer_o(defer)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_cnt, m_cmp, m_nc;
  bit m_up, m_e, m_d, m_now;
  int pend_q[$];

  function automatic int scale(int d);
    return ((d + 2 ** (DW - 1)) * PEAK) / (2 ** DW);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_up = 1; m_cmp = 0; m_e = 0; m_d = 0;
      pend_q.delete();
    end else begin
      m_e = 0; m_d = 0;
      if (cmd_valid) begin
        m_nc  = scale(int'($signed(cmd_duty)));
        m_now = m_up ? (m_cnt < m_cmp) : (m_cnt >= m_cmp);
        if (m_now) begin m_cmp = m_nc; m_e = 1; end
        else begin pend_q.push_back(m_nc); m_d = 1; end
      end
      if (m_up) begin
        m_cnt++;
        if (m_cnt == PEAK) m_up = 0;
      end else begin
        m_cnt--;
        if (m_cnt == 0) m_up = 1;
      end
      if ((m_cnt == 0 || m_cnt == PEAK) && pend_q.size() > 0) begin
        m_cmp = pend_q[pend_q.size() - 1];
        pend_q.delete();
      end
    end
  end

  // Per-cycle comparison and edge counting
  bit prev_g;
  int rises, falls;

  always @(negedge clk) begin
    if (rst_n) begin
      check("R1", "carrier", int'(carrier), m_cnt);
      check("R1", "rising", int'(rising), int'(m_up));
      check("R10", "sample", int'(sample),
            int'(m_cnt == 0 || m_cnt == PEAK || m_cnt == PEAK / 2));
      check("R4/R5/R6/R7", "compare", int'(cmp), m_cmp);
      check("R3", "gate", int'(gate), int'(m_cnt < m_cmp));
      check("R4", "early", int'(early), int'(m_e));
      check("R5", "defer", int'(defer), int'(m_d));
      if (carrier == CW'(PEAK)) begin
        rises = 0;
        check("R8", "gate at peak", int'(gate), 0);
      end
      if (carrier == '0 && rising) falls = 0;
      if (gate && !prev_g) rises++;
      if (!gate && prev_g) falls++;
      check("R8", "rises per window", int'(rises > 1), 0);
      check("R8", "falls per window", int'(falls > 1), 0);
      prev_g = gate;
    end else begin
      prev_g = 0; rises = 0; falls = 0;
    end
  end

  task automatic wait_at(int c, bit up);
    while (!(int'(carrier) == c && rising == up)) @(negedge clk);
  endtask

  task automatic send(int d);
    cmd_valid = 1'b1;
    cmd_duty  = DW'(d);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R9: reset state
    check("R9", "carrier", int'(carrier), 0);
    check("R9", "rising", int'(rising), 1);
    check("R9", "compare", int'(cmp), 0);
    check("R9", "gate", int'(gate), 0);
    check("R9", "flags", int'(early) + int'(defer), 0);
    rst_n = 1'b1;

    // R5: rising slope, already crossed (cmp 0) -> deferred to peak
    wait_at(3, 1'b1);
    send(0);
    check("R5", "defer pulse", int'(defer), 1);
    check("R5", "cmp held", int'(cmp), 0);
    wait_at(PEAK, 1'b0);
    check("R5", "cmp at peak", int'(cmp), 20);

    // R4: rising slope before crossing -> immediate
    wait_at(5, 1'b1);
    send(-256);
    check("R4", "early pulse", int'(early), 1);
    check("R4", "cmp now", int'(cmp), 10);
    check("R4", "gate still high", int'(gate), 1);

    // R5: rising slope after crossing -> deferred
    wait_at(12, 1'b1);
    send(256);
    check("R5", "defer pulse", int'(defer), 1);
    check("R5", "gate stays low", int'(gate), 0);
    wait_at(PEAK - 1, 1'b1);
    check("R5", "cmp before peak", int'(cmp), 10);
    wait_at(PEAK, 1'b0);
    check("R5", "cmp at peak", int'(cmp), 30);

    // R6: falling slope before crossing -> immediate
    wait_at(35, 1'b0);
    send(-256);
    check("R6", "early pulse", int'(early), 1);
    check("R6", "cmp now", int'(cmp), 10);

    // R6/R7: falling slope after crossing, two deferred commands
    wait_at(8, 1'b0);
    send(0);
    check("R6", "defer pulse", int'(defer), 1);
    wait_at(5, 1'b0);
    send(256);
    check("R7", "cmp held", int'(cmp), 10);
    wait_at(0, 1'b1);
    check("R7", "newest loaded at valley", int'(cmp), 30);

    // R2: extreme codes
    send(511);
    check("R2", "max code", int'(cmp), 39);
    wait_at(39, 1'b0);
    send(-512);
    check("R2", "min code", int'(cmp), 0);
    check("R2", "gate low", int'(gate), 0);

    // R10: mid-slope strobe
    wait_at(PEAK / 2, 1'b1);
    check("R10", "mid strobe rising", int'(sample), 1);
    wait_at(PEAK / 2, 1'b0);
    check("R10", "mid strobe falling", int'(sample), 1);

    // Commands a short compute delay after each sample strobe
    for (int i = 0; i < 120; i++) begin
      while (!sample) @(negedge clk);
      repeat ($urandom_range(0, 9)) @(negedge clk);
      send(int'($urandom_range(0, 1023)) - 512);
    end

    // Random command stream
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 3) == 0) send(int'($urandom_range(0, 1023)) - 512);
      else @(negedge clk);
    end

    repeat (2 * PEAK) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", WDOG, 0);
      finish_run();
    end
  end

endmodule